// File: doc/BRIEF.md
# Framebuffer pixel format selector

The block takes 32-bit words read from a framebuffer and splits each one into pixels for a display pipeline. It emits one pixel per cycle. Each pixel is either a palette index, in the modes of eight bits per pixel or fewer, or a direct colour with 8 bits per channel, in the 12-, 16- and 32-bit modes. The pixel format comes from a 3-bit depth code, a colour-order select, two ordering selects and a 2-bit layout code for the 16-bit mode. A strap chooses between the base and the extended variant of the format decode.

Input words arrive on a valid/ready handshake. The block accepts a word only when it is idle. It latches the word together with the decoded format, then emits every pixel of that word on consecutive cycles before it raises ready again. The output side has no backpressure.

The block also reports, combinationally, the number of framebuffer bytes in one scan line. This count is computed from a line width in pixels and the current depth code. The depth code, the ordering selects, the layout code and the strap are sampled when a word is accepted.

Top module: `fb_pixel_unpack`

## Requirements
- R1: After reset, `in_ready` is 1 and `pix_valid` is 0.
- R2: Depth codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bits per pixel. Each word yields 32/bits pixels with `pix_is_index`=1 and the index zero-extended into `pix_index`. With both ordering selects low, pixel k is word bits [k*bits +: bits], so the first pixel comes from the least significant bits.
- R3: A word is accepted in a cycle where `in_valid` and `in_ready` are both 1. Its pixels then appear on the following consecutive cycles with `pix_valid`=1, and `in_ready` stays 0 throughout. `in_ready` returns to 1 in the cycle after the last pixel.
- R4: With `byte_be`=1, the four bytes of the word are reversed before extraction: byte 3 moves to bits [7:0], and the other bytes follow in reverse order. `pix_be` then has no effect.
- R5: With `pix_be`=1 and `byte_be`=0, the pixels inside each byte are taken from the most significant end first. Bytes are still taken from the least significant end first. For 8 bits per pixel and wider, this select changes nothing.
- R6: In the 5-5-5-1 layout (16-bit slot), the fields are bits [4:0], [9:5] and [14:10], and bit 15 is ignored. The middle field is green. With `bgr_sel`=1 the low field is red and the high field is blue; with `bgr_sel`=0 they are exchanged. Every channel is output left-shifted to 8 bits, and direct colours have `pix_is_index`=0.
- R7: The 5-6-5 layout uses fields [4:0], [10:5] and [15:11], and red and blue are placed as in R6. On the base variant with depth code 4, mux codes 0 and 2 select 5-6-5 and honour `bgr_sel`. Mux code 3 selects 5-6-5 with the low field always red, whatever `bgr_sel` is.
- R8: On the base variant with depth code 4, mux code 1 selects the 5-5-5-1 layout. On the base variant, codes 6 and 7 decode exactly as code 4.
- R9: On the extended variant (`ext_mode`=1), `mux_sel` is ignored. Depth code 4 gives 5-5-5-1 and code 6 gives 5-6-5 with `bgr_sel` honoured.
- R10: Extended depth code 7 gives 4-4-4 colour in a 16-bit slot. The fields are bits [3:0], [7:4] and [11:8], red and blue are placed as in R6, and each channel is shifted left by 4.
- R11: Depth code 5 gives one pixel per word. The fields are bits [7:0], [15:8] and [23:16], bits [31:24] are ignored, and red and blue are placed as in R6.
- R12: `line_bytes` is floor(width*bits/8) for the live depth code, where bits is the pixel depth. That is width/8, width/4, width/2, width, width*2 for every 16-bit and 12-bit mode, and width*4 for 32-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | Variant strap: 1 selects extended decode |
| bpp_code | input | 3 | Pixel depth code |
| bgr_sel | input | 1 | Colour order: 1 puts red in the low field |
| byte_be | input | 1 | Reverse byte order of each word |
| pix_be | input | 1 | Reverse pixel order inside each byte |
| mux_sel | input | 2 | 16-bit layout code for the base variant |
| line_width | input | WIDTH_W | Scan line width in pixels |
| line_bytes | output | WIDTH_W+2 | Framebuffer bytes per scan line |
| in_data | input | WORD_W | Framebuffer word |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Block can take a word |
| pix_valid | output | 1 | Pixel outputs valid |
| pix_is_index | output | 1 | 1: palette index, 0: direct colour |
| pix_index | output | 8 | Palette index |
| pix_red | output | 8 | Red channel |
| pix_green | output | 8 | Green channel |
| pix_blue | output | 8 | Blue channel |

## Verification
The bench feeds asymmetric words in every depth code. A swapped shift direction would show up as mirrored index sequences, and a wrong pixel count as a surplus or missing pixel in the scoreboard. Both ordering selects are driven together, to catch a design that lets pixel reversal override byte reversal. In the 16-bit modes, each mux code is combined with both colour orders and both variants. This exposes a fixed-order code that still swaps red and blue, and an extended variant that still listens to the mux. The scan line byte count is checked at each depth, including a width that does not divide evenly at 1 bit per pixel, where rounding up instead of truncating gives one byte too many.

// File: rtl/fbpx_pkg.sv
package fbpx_pkg;

    typedef enum logic [2:0] {
        FMT_IDX     = 3'd0,
        FMT_5551    = 3'd1,
        FMT_565     = 3'd2,
        FMT_565_FIX = 3'd3,
        FMT_444     = 3'd4,
        FMT_888     = 3'd5
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [2:0] lb;          // log2 of slot bits
        logic       swap_bytes;
        logic       mirror_pix;
        logic       bgr;
    } cfg_t;

endpackage

// File: rtl/fbpx_decode.sv
module fbpx_decode
    import fbpx_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  logic [2:0]         bpp_code,
    input  logic               ext_mode,
    input  logic [1:0]         mux_sel,
    input  logic               bgr_sel,
    input  logic               byte_be,
    input  logic               pix_be,
    input  logic [WIDTH_W-1:0] line_width,
    output cfg_t               cfg,
    output logic [WIDTH_W+1:0] line_bytes
);
    localparam int TMP_W = WIDTH_W + 5;

    logic [TMP_W-1:0] bits_total;

    function automatic fmt_e base16(input logic [1:0] m);
        case (m)
            2'd1:    return FMT_5551;
            2'd3:    return FMT_565_FIX;
            default: return FMT_565;
        endcase
    endfunction

    always_comb begin
        cfg            = '0;
        cfg.swap_bytes = byte_be;
        cfg.mirror_pix = pix_be & ~byte_be;
        cfg.bgr        = bgr_sel;
        case (bpp_code)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                cfg.fmt = FMT_IDX;
                cfg.lb  = bpp_code;
            end
            3'd5: begin
                cfg.fmt = FMT_888;
                cfg.lb  = 3'd5;
            end
            3'd6: begin
                cfg.fmt = ext_mode ? FMT_565 : base16(mux_sel);
                cfg.lb  = 3'd4;
            end
            3'd7: begin
                cfg.fmt = ext_mode ? FMT_444 : base16(mux_sel);
                cfg.lb  = 3'd4;
            end
            default: begin
                cfg.fmt = ext_mode ? FMT_5551 : base16(mux_sel);
                cfg.lb  = 3'd4;
            end
        endcase
    end

    always_comb begin
        bits_total = TMP_W'(line_width) << cfg.lb;
        line_bytes = (WIDTH_W+2)'(bits_total >> 3);
    end

endmodule

// File: rtl/fbpx_extract.sv
module fbpx_extract
    import fbpx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]         word,
    input  logic [$clog2(WORD_W)-1:0] idx,
    input  cfg_t                      cfg,
    output logic [23:0]               raw
);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] rev;
    logic [WORD_W-1:0] src;
    logic [IDX_W-1:0]  off;
    logic [23:0]       mask;

    for (genvar b = 0; b < NBYTES; b++) begin : g_rev
        assign rev[8*b +: 8] = word[8*(NBYTES-1-b) +: 8];
    end

    always_comb begin
        src = cfg.swap_bytes ? rev : word;
        off = IDX_W'(idx << cfg.lb);
        if (cfg.mirror_pix && (cfg.lb < 3'd3)) begin
            off[2:0] = 3'(4'd8 - (4'd1 << cfg.lb)) - off[2:0];
        end
        mask = 24'(~({WORD_W{1'b1}} << (6'd1 << cfg.lb)));
        raw  = 24'(src >> off) & mask;
    end

endmodule

// File: rtl/fbpx_color.sv
module fbpx_color
    import fbpx_pkg::*;
(
    input  logic [23:0] raw,
    input  cfg_t        cfg,
    output logic        is_index,
    output logic [7:0]  index,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);
    logic [7:0] lo, mid, hi;
    logic       swap_rb;

    always_comb begin
        lo  = '0;
        mid = '0;
        hi  = '0;
        case (cfg.fmt)
            FMT_5551: begin
                lo  = {raw[4:0], 3'b0};
                mid = {raw[9:5], 3'b0};
                hi  = {raw[14:10], 3'b0};
            end
            FMT_565, FMT_565_FIX: begin
                lo  = {raw[4:0], 3'b0};
                mid = {raw[10:5], 2'b0};
                hi  = {raw[15:11], 3'b0};
            end
            FMT_444: begin
                lo  = {raw[3:0], 4'b0};
                mid = {raw[7:4], 4'b0};
                hi  = {raw[11:8], 4'b0};
            end
            FMT_888: begin
                lo  = raw[7:0];
                mid = raw[15:8];
                hi  = raw[23:16];
            end
            default: ;
        endcase
        swap_rb  = (cfg.fmt == FMT_565_FIX) ? 1'b0 : ~cfg.bgr;
        is_index = (cfg.fmt == FMT_IDX);
        index    = is_index ? raw[7:0] : 8'h00;
        red      = swap_rb ? hi : lo;
        green    = mid;
        blue     = swap_rb ? lo : hi;
    end

endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
    import fbpx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [2:0]         bpp_code,
    input  logic               bgr_sel,
    input  logic               byte_be,
    input  logic               pix_be,
    input  logic [1:0]         mux_sel,
    input  logic [WIDTH_W-1:0] line_width,
    output logic [WIDTH_W+1:0] line_bytes,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic               pix_valid,
    output logic               pix_is_index,
    output logic [7:0]         pix_index,
    output logic [7:0]         pix_red,
    output logic [7:0]         pix_green,
    output logic [7:0]         pix_blue
);
    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        cfg_t              cfg;
    } state_t;

    state_t           state_d, state_q;
    cfg_t             cfg_live;
    logic [IDX_W-1:0] last_idx;
    logic [23:0]      raw;

    fbpx_decode #(.WIDTH_W(WIDTH_W)) u_decode (
        .bpp_code   (bpp_code),
        .ext_mode   (ext_mode),
        .mux_sel    (mux_sel),
        .bgr_sel    (bgr_sel),
        .byte_be    (byte_be),
        .pix_be     (pix_be),
        .line_width (line_width),
        .cfg        (cfg_live),
        .line_bytes (line_bytes)
    );

    fbpx_extract #(.WORD_W(WORD_W)) u_extract (
        .word (state_q.word),
        .idx  (state_q.idx),
        .cfg  (state_q.cfg),
        .raw  (raw)
    );

    fbpx_color u_color (
        .raw      (raw),
        .cfg      (state_q.cfg),
        .is_index (pix_is_index),
        .index    (pix_index),
        .red      (pix_red),
        .green    (pix_green),
        .blue     (pix_blue)
    );

    assign last_idx  = IDX_W'((WORD_W >> state_q.cfg.lb) - 1);
    assign in_ready  = ~state_q.busy;
    assign pix_valid = state_q.busy;

    always_comb begin
        state_d = state_q;
        if (!state_q.busy) begin
            if (in_valid) begin
                state_d.busy = 1'b1;
                state_d.idx  = '0;
                state_d.word = in_data;
                state_d.cfg  = cfg_live;
            end
        end else if (state_q.idx == last_idx) begin
            state_d.busy = 1'b0;
        end else begin
            state_d.idx = state_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    p_accept_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> pix_valid);

    p_hold_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && state_q.idx != last_idx) |=> (pix_valid && !in_ready));

    p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && state_q.idx != last_idx) |=> $stable(state_q.word));

    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (state_q.idx <= last_idx));

    p_index_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_is_index) |-> ({pix_red, pix_green, pix_blue} == 24'h0));

    p_lb32_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bpp_code == 3'd5) |-> (line_bytes == {line_width, 2'b00}));

endmodule

// File: tb/sim_fb_pixel_unpack.sv
module sim_fb_pixel_unpack;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [2:0]  bpp_code = 3'd0;
    logic        bgr_sel = 1'b0;
    logic        byte_be = 1'b0;
    logic        pix_be = 1'b0;
    logic [1:0]  mux_sel = 2'd0;
    logic [11:0] line_width = 12'd320;
    logic [13:0] line_bytes;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, pix_valid, pix_is_index;
    logic [7:0]  pix_index, pix_red, pix_green, pix_blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [32:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fb_pixel_unpack u0 (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .bpp_code(bpp_code),
        .bgr_sel(bgr_sel), .byte_be(byte_be), .pix_be(pix_be), .mux_sel(mux_sel),
        .line_width(line_width), .line_bytes(line_bytes),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .pix_valid(pix_valid), .pix_is_index(pix_is_index), .pix_index(pix_index),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    function automatic int bits_of();
        case (bpp_code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd5: return 32;
            default: return 16;
        endcase
    endfunction

    // 0:5551 1:565 2:565 fixed 3:444 4:888
    function automatic int fmt_of();
        if (bpp_code == 3'd5) return 4;
        if (ext_mode) begin
            if (bpp_code == 3'd6) return 1;
            if (bpp_code == 3'd7) return 3;
            return 0;
        end
        if (mux_sel == 2'd1) return 0;
        if (mux_sel == 2'd3) return 2;
        return 1;
    endfunction

    function automatic logic [32:0] model(input logic [31:0] w, input int k);
        int bits, ppb, bi, sub, f;
        logic [7:0] by, lo, mid, hi, r, b;
        logic [31:0] ww, v;
        bits = bits_of();
        if (bits < 8) begin
            ppb = 8 / bits;
            bi  = k / ppb;
            sub = k % ppb;
            by  = byte_be ? w[8*(3-bi) +: 8] : w[8*bi +: 8];
            if (pix_be && !byte_be) sub = ppb - 1 - sub;
            v = 32'(by >> (sub*bits)) & ((32'd1 << bits) - 1);
            return {1'b1, v[7:0], 24'h0};
        end
        ww = byte_be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        v  = ww >> (k*bits);
        if (bits == 8) return {1'b1, v[7:0], 24'h0};
        f = fmt_of();
        case (f)
            0: begin lo = {v[4:0],3'b0}; mid = {v[9:5],3'b0}; hi = {v[14:10],3'b0}; end
            1, 2: begin lo = {v[4:0],3'b0}; mid = {v[10:5],2'b0}; hi = {v[15:11],3'b0}; end
            3: begin lo = {v[3:0],4'b0}; mid = {v[7:4],4'b0}; hi = {v[11:8],4'b0}; end
            default: begin lo = v[7:0]; mid = v[15:8]; hi = v[23:16]; end
        endcase
        if (f != 2 && !bgr_sel) begin r = hi; b = lo; end
        else begin r = lo; b = hi; end
        return {1'b0, 8'h00, r, mid, b};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [32:0] act,
                         input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(in_ready && q.size() == 0));
    endtask

    task automatic send(input logic [31:0] w, input string tag);
        int n;
        exp_t e;
        n = 32 / bits_of();
        for (int k = 0; k < n; k++) begin
            e.v = model(w, k);
            e.tag = tag;
            q.push_back(e);
        end
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hDEAD_BEEF;
        wait_idle();
        check(in_ready === 1'b1, "R3 ready after last pixel", {32'b0, in_ready}, 33'd1);
    endtask

    task automatic set_mode(input logic ex, input logic [2:0] code, input logic bgr,
                            input logic bb, input logic pb, input logic [1:0] mx);
        ext_mode = ex; bpp_code = code; bgr_sel = bgr;
        byte_be = bb; pix_be = pb; mux_sel = mx;
    endtask

    task automatic check_lb(input logic ex, input logic [2:0] code, input int width,
                            input int bits);
        int exp;
        ext_mode = ex; bpp_code = code; line_width = 12'(width);
        #1;
        exp = (width * bits) / 8;
        check(line_bytes == 14'(exp), "R12 line bytes", {19'b0, line_bytes}, 33'(exp));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && pix_valid) begin
            check(in_ready === 1'b0, "R3 ready low while pending", {32'b0, in_ready}, 33'd0);
            if (q.size() == 0) begin
                check(1'b0, "R3 surplus pixel",
                      {pix_is_index, pix_index, pix_red, pix_green, pix_blue}, 33'h0);
            end else begin
                e = q.pop_front();
                check({pix_is_index, pix_index, pix_red, pix_green, pix_blue} === e.v, e.tag,
                      {pix_is_index, pix_index, pix_red, pix_green, pix_blue}, e.v);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 40000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready === 1'b1, "R1 in_ready at reset", {32'b0, in_ready}, 33'd1);
        check(pix_valid === 1'b0, "R1 pix_valid at reset", {32'b0, pix_valid}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 indexed modes, little-endian
        set_mode(0, 3'd0, 1, 0, 0, 0); send(32'hA5C3_0F81, "R2 1bpp");
        set_mode(0, 3'd1, 1, 0, 0, 0); send(32'h1B2E_9C47, "R2 2bpp");
        set_mode(0, 3'd2, 1, 0, 0, 0); send(32'h8765_4321, "R2 4bpp");
        set_mode(0, 3'd3, 1, 0, 0, 0); send(32'hF0A1_3C02, "R2 8bpp");
        // R5 pixel reversal inside bytes
        set_mode(0, 3'd0, 1, 0, 1, 0); send(32'h0180_0F71, "R5 1bpp mirror");
        set_mode(0, 3'd2, 1, 0, 1, 0); send(32'h8765_4321, "R5 4bpp mirror");
        set_mode(0, 3'd3, 1, 0, 1, 0); send(32'h1234_5678, "R5 8bpp unaffected");
        // R4 byte reversal, priority over pixel reversal
        set_mode(0, 3'd3, 1, 1, 0, 0); send(32'h1234_5678, "R4 8bpp bytes");
        set_mode(0, 3'd0, 1, 1, 1, 0); send(32'hA5C3_0F81, "R4 1bpp priority");
        set_mode(0, 3'd1, 1, 1, 1, 0); send(32'h1B2E_9C47, "R4 2bpp priority");
        // R8 base variant 5551 via mux code 1, R6 colour order
        set_mode(0, 3'd4, 1, 0, 0, 1); send(32'hFC1F_83E0, "R8 R6 5551 bgr");
        set_mode(0, 3'd4, 0, 0, 0, 1); send(32'h7C01_8421, "R8 R6 5551 rgb");
        set_mode(0, 3'd6, 1, 0, 0, 1); send(32'h7C01_8421, "R8 code6 as code4");
        // R7 565 selection
        set_mode(0, 3'd4, 1, 0, 0, 0); send(32'hF800_07E1, "R7 565 mux0 bgr");
        set_mode(0, 3'd4, 0, 0, 0, 2); send(32'hF800_07E1, "R7 565 mux2 rgb");
        set_mode(0, 3'd4, 0, 0, 0, 3); send(32'hF800_07E1, "R7 565 mux3 fixed");
        set_mode(0, 3'd7, 0, 0, 0, 3); send(32'h1234_ABCD, "R7 code7 fixed");
        set_mode(0, 3'd4, 1, 1, 0, 0); send(32'h1F00_E007, "R4 565 bytes");
        // R9 extended variant ignores mux
        set_mode(1, 3'd4, 1, 0, 0, 3); send(32'h8421_7C01, "R9 ext 5551 mux3");
        set_mode(1, 3'd6, 0, 0, 0, 1); send(32'hF800_07E1, "R9 ext 565 mux1");
        set_mode(1, 3'd6, 0, 0, 0, 3); send(32'hF800_07E1, "R9 ext 565 mux3");
        // R10 12-bit
        set_mode(1, 3'd7, 1, 0, 0, 2); send(32'hF123_0ABC, "R10 444 bgr");
        set_mode(1, 3'd7, 0, 0, 0, 0); send(32'hF123_0ABC, "R10 444 rgb");
        // R11 32-bit
        set_mode(0, 3'd5, 1, 0, 0, 0); send(32'hEE11_2233, "R11 888 bgr");
        set_mode(0, 3'd5, 0, 0, 0, 0); send(32'h5511_2233, "R11 888 rgb");
        set_mode(1, 3'd5, 0, 1, 0, 0); send(32'h1122_33AA, "R11 888 bytes");

        // R12 line byte count
        check_lb(0, 3'd0, 320, 1);
        check_lb(0, 3'd0, 100, 1);
        check_lb(0, 3'd1, 320, 2);
        check_lb(0, 3'd2, 320, 4);
        check_lb(0, 3'd3, 320, 8);
        check_lb(0, 3'd4, 320, 16);
        check_lb(1, 3'd6, 640, 16);
        check_lb(1, 3'd7, 640, 16);
        check_lb(0, 3'd5, 4095, 32);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R3 all expected pixels seen", 33'(q.size()), 33'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule